// File: doc/BRIEF.md
# Double-Buffered Stream Sequencer

This block moves 32-bit sample words between a word-wide memory port and a serial audio engine's word stream. Transmit only, receive only or full duplex can be selected. Software programs a transmit pointer, a receive pointer and one word count that both directions share, then issues START. The block copies the pointer registers into its own working pointers and raises a pointer-update event for each active direction. From then on the registers are free to hold the next buffer's pointers while the current buffer streams.

When a buffer's last word finishes, the block raises a count-reached event and copies the registers again. If software has not rewritten them by then, the same buffer simply plays again. STOP lets the word in flight complete, then the block goes idle and raises a stopped event. Events are sticky. Each has its own enable, and these enables combine into one interrupt line.

Top module: `dss_stream_seq`

## Requirements
- R1: After reset all four event bits are 0 and `irq`, `mem_req`, `tx_valid` and `rx_ready` are 0.
- R2: A START accepted while idle copies the pointer and count registers. In the next cycle it sets the pointer-update events of the active directions only. `cfg_dir` bit 0 enables transmit and bit 1 enables receive. Event bit 0 is transmit pointer update and bit 1 is receive pointer update.
- R3: A memory request keeps its address and direction until `mem_ack`. Each acknowledged word advances that direction's working address by 4 bytes.
- R4: In transmit-only mode the transmit words are the memory words read from the working pointer in order. `rx_ready` stays 0 and no memory write is issued.
- R5: In receive-only mode every transmit word is zero and no memory read is issued. Received words are written to memory in arrival order.
- R6: In duplex mode each word step reads one transmit word from memory, hands it to the engine, accepts one receive word and then writes it to memory.
- R7: After `cfg_count` words the block sets the count-reached event (bit 2), sets the active pointer-update events again and copies the pointer registers once more. Pointers that were not rewritten replay the previous buffer.
- R8: STOP lets the word in flight complete, including the receive write in duplex mode. The stopped event (bit 3) is visible in the cycle right after the last handshake, and no request follows.
- R9: Event bits are sticky. Writing a 1 in `evt_clr` clears that bit, and a later START does not clear leftover bits.
- R10: `irq` is the OR of the enabled event bits. A pointer-update bit counts only while its direction is part of the latched direction.
- R11: START with a zero count or with `cfg_dir` = 00 is ignored, and STOP while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_tx_ptr | input | AW | Transmit buffer byte address register |
| cfg_rx_ptr | input | AW | Receive buffer byte address register |
| cfg_count | input | CW | Buffer length in words, shared by both directions |
| cfg_dir | input | 2 | Bit 0 transmit enable, bit 1 receive enable |
| cfg_inten | input | 4 | Per-event interrupt enables |
| task_start | input | 1 | One-cycle START task |
| task_stop | input | 1 | One-cycle STOP task |
| evt_clr | input | 4 | Write-one-to-clear for event bits |
| evt | output | 4 | Sticky events: 0 tx ptr update, 1 rx ptr update, 2 count reached, 3 stopped |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 for write (receive data), 0 for read |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| tx_valid | output | 1 | Transmit word offered to the engine |
| tx_ready | input | 1 | Engine takes the transmit word |
| tx_data | output | DW | Transmit word |
| rx_valid | input | 1 | Engine offers a receive word |
| rx_ready | output | 1 | Block accepts the receive word |
| rx_data | input | DW | Receive word |

## Verification
The stream is run in each of the three directions while memory acknowledge, engine ready and engine valid vary at random. Transmit-only runs show whether data comes from the working pointer and whether the receive side stays silent. Receive-only runs tell zero transmit data apart from stale memory data. Duplex runs show whether the read–hand-over–accept–write order holds. A pointer rewrite in the middle of the second buffer separates replay of the first buffer from an early or late re-latch. STOP issued at random word phases, with the latency counted from the last handshake, separates a word-granular stop from an immediate stop or a buffer-granular stop.

// File: rtl/dss_pkg.sv
// Shared definitions for the double-buffered stream sequencer.
// Assumes: four event bits in the fixed order below; software decodes them.
package dss_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TXRD  = 3'd1,
        ST_TXOUT = 3'd2,
        ST_RXIN  = 3'd3,
        ST_RXWR  = 3'd4
    } step_e;

    localparam int NEV     = 4;
    localparam int EV_TXPU = 0;
    localparam int EV_RXPU = 1;
    localparam int EV_CNT  = 2;
    localparam int EV_STOP = 3;
endpackage

// File: rtl/dss_step.sv
// Word stepper: walks one word through memory read, hand-over to the
// engine, receive accept and memory write, skipping the steps of an
// inactive direction. Assumes go is raised only while idle.
module dss_step
    import dss_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          tx_act,
    input  logic          rx_act,
    input  logic          stop_req,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  logic          tx_ready,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          rx_ready,
    output logic          busy,
    output logic          tx_adv,
    output logic          rx_adv,
    output logic          word_done,
    output logic          stop_fin
);
    step_e st, st_nx, first_st;
    logic stop_pend, stop_now;
    logic [DW-1:0] tx_hold, rx_hold;

    assign first_st = tx_act ? ST_TXRD : ST_TXOUT;
    assign stop_now = stop_pend | stop_req;
    assign busy     = (st != ST_IDLE);

    // Next step of the word sequence.
    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:  if (go) st_nx = first_st;
            ST_TXRD:  if (mem_ack) st_nx = ST_TXOUT;
            ST_TXOUT: if (tx_ready) st_nx = rx_act ? ST_RXIN : (stop_now ? ST_IDLE : first_st);
            ST_RXIN:  if (rx_valid) st_nx = ST_RXWR;
            ST_RXWR:  if (mem_ack) st_nx = stop_now ? ST_IDLE : first_st;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Remember a STOP until the current word ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                 stop_pend <= 1'b0;
        else if (st_nx == ST_IDLE)  stop_pend <= 1'b0;
        else if (stop_req && busy)  stop_pend <= 1'b1;
    end

    // Hold the fetched transmit word and the accepted receive word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold <= '0;
            rx_hold <= '0;
        end else begin
            if (st == ST_TXRD && mem_ack)  tx_hold <= mem_rdata;
            if (st == ST_RXIN && rx_valid) rx_hold <= rx_data;
        end
    end

    assign mem_req   = (st == ST_TXRD) || (st == ST_RXWR);
    assign mem_we    = (st == ST_RXWR);
    assign mem_wdata = rx_hold;
    assign tx_valid  = (st == ST_TXOUT);
    assign tx_data   = tx_act ? tx_hold : '0;
    assign rx_ready  = (st == ST_RXIN);
    assign tx_adv    = (st == ST_TXRD) && mem_ack;
    assign rx_adv    = (st == ST_RXWR) && mem_ack;
    assign word_done = ((st == ST_TXOUT) && tx_ready && !rx_act) || rx_adv;
    assign stop_fin  = word_done && stop_now;
endmodule

// File: rtl/dss_ptrs.sv
// Working pointers and word index. Copies the pointer and count registers
// on START and at every buffer boundary; otherwise advances per word.
// Assumes cfg_count is nonzero whenever go is raised.
module dss_ptrs #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] cfg_tx_ptr,
    input  logic [AW-1:0] cfg_rx_ptr,
    input  logic [CW-1:0] cfg_count,
    input  logic          tx_adv,
    input  logic          rx_adv,
    input  logic          word_done,
    output logic [AW-1:0] tx_wp,
    output logic [AW-1:0] rx_wp,
    output logic          boundary
);
    localparam logic [AW-1:0] STEP_B = AW'(DW / 8);
    localparam logic [CW-1:0] ONE    = CW'(1);

    logic [CW-1:0] len, idx;

    assign boundary = word_done && (idx == len - ONE);

    // Latch on start or boundary, else step addresses and the word index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_wp <= '0;
            rx_wp <= '0;
            len   <= ONE;
            idx   <= '0;
        end else if (go || boundary) begin
            tx_wp <= cfg_tx_ptr;
            rx_wp <= cfg_rx_ptr;
            len   <= cfg_count;
            idx   <= '0;
        end else begin
            if (tx_adv)    tx_wp <= tx_wp + STEP_B;
            if (rx_adv)    rx_wp <= rx_wp + STEP_B;
            if (word_done) idx   <= idx + ONE;
        end
    end
endmodule

// File: rtl/dss_events.sv
// Sticky event bits with write-one-to-clear and the interrupt combiner.
// Assumes a set and a clear of the same bit in one cycle leave it set.
module dss_events
    import dss_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] set,
    input  logic [NEV-1:0] clr,
    input  logic [NEV-1:0] inten,
    input  logic           act_tx,
    input  logic           act_rx,
    output logic [NEV-1:0] evt,
    output logic           irq
);
    logic [NEV-1:0] dir_mask;

    for (genvar k = 0; k < NEV; k++) begin : g_ev
        // One sticky flag per event.
        always_ff @(posedge clk) begin
            if (!rst_n)      evt[k] <= 1'b0;
            else if (set[k]) evt[k] <= 1'b1;
            else if (clr[k]) evt[k] <= 1'b0;
        end
    end

    // Pointer-update events count only for the latched directions.
    always_comb begin
        dir_mask          = '1;
        dir_mask[EV_TXPU] = act_tx;
        dir_mask[EV_RXPU] = act_rx;
    end

    assign irq = |(evt & inten & dir_mask);
endmodule

// File: rtl/dss_stream_seq.sv
// Top of the double-buffered stream sequencer: accepts START/STOP tasks,
// latches the direction, and joins the word stepper, pointer unit and
// event unit. Assumes one memory port shared by both directions.
module dss_stream_seq
    import dss_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  cfg_tx_ptr,
    input  logic [AW-1:0]  cfg_rx_ptr,
    input  logic [CW-1:0]  cfg_count,
    input  logic [1:0]     cfg_dir,
    input  logic [NEV-1:0] cfg_inten,
    input  logic           task_start,
    input  logic           task_stop,
    input  logic [NEV-1:0] evt_clr,
    output logic [NEV-1:0] evt,
    output logic           irq,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_ack,
    input  logic [DW-1:0]  mem_rdata,
    output logic           tx_valid,
    input  logic           tx_ready,
    output logic [DW-1:0]  tx_data,
    input  logic           rx_valid,
    output logic           rx_ready,
    input  logic [DW-1:0]  rx_data
);
    logic [1:0]     act_dir, dir_eff;
    logic           go, busy, tx_adv, rx_adv, word_done, stop_fin, boundary;
    logic [AW-1:0]  tx_wp, rx_wp;
    logic [NEV-1:0] ev_set;

    assign go      = task_start && !busy && (cfg_dir != 2'b00) && (cfg_count != '0);
    assign dir_eff = go ? cfg_dir : act_dir;

    // Latch the direction of an accepted START.
    always_ff @(posedge clk) begin
        if (!rst_n)  act_dir <= 2'b00;
        else if (go) act_dir <= cfg_dir;
    end

    dss_step #(.DW(DW)) u_step (
        .clk(clk), .rst_n(rst_n), .go(go),
        .tx_act(dir_eff[0]), .rx_act(dir_eff[1]), .stop_req(task_stop),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .rx_ready(rx_ready),
        .busy(busy), .tx_adv(tx_adv), .rx_adv(rx_adv),
        .word_done(word_done), .stop_fin(stop_fin)
    );

    dss_ptrs #(.AW(AW), .DW(DW), .CW(CW)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .go(go),
        .cfg_tx_ptr(cfg_tx_ptr), .cfg_rx_ptr(cfg_rx_ptr), .cfg_count(cfg_count),
        .tx_adv(tx_adv), .rx_adv(rx_adv), .word_done(word_done),
        .tx_wp(tx_wp), .rx_wp(rx_wp), .boundary(boundary)
    );

    assign mem_addr = mem_we ? rx_wp : tx_wp;

    // Event sources: start and boundary re-latches, count reached, stop.
    always_comb begin
        ev_set          = '0;
        ev_set[EV_TXPU] = (go && cfg_dir[0]) || (boundary && act_dir[0]);
        ev_set[EV_RXPU] = (go && cfg_dir[1]) || (boundary && act_dir[1]);
        ev_set[EV_CNT]  = boundary;
        ev_set[EV_STOP] = stop_fin;
    end

    dss_events u_ev (
        .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(evt_clr),
        .inten(cfg_inten), .act_tx(act_dir[0]), .act_rx(act_dir[1]),
        .evt(evt), .irq(irq)
    );
endmodule

// File: rtl/dss_seq_chk.sv
// Property checker for dss_stream_seq, attached by bind below.
// Assumes synchronous active-low reset on rst_n.
module dss_seq_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          tx_valid,
    input logic [DW-1:0] tx_data,
    input logic          rx_ready,
    input logic [3:0]    evt,
    input logic [3:0]    evt_clr,
    input logic [3:0]    cfg_inten,
    input logic          irq,
    input logic [1:0]    act_dir
);
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r4_tx_only_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (act_dir == 2'b01) |-> (!(mem_req && mem_we) && !rx_ready));

    a_r5_rx_only_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (act_dir == 2'b10 && tx_valid) |-> (tx_data == '0));

    a_r5_rx_only_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (act_dir == 2'b10) |-> !(mem_req && !mem_we));

    a_r8_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt[3]) |-> (!mem_req && !tx_valid && !rx_ready));

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt & ~evt_clr)) |=> ((evt & $past(evt & ~evt_clr)) == $past(evt & ~evt_clr)));

    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(evt & cfg_inten)));
endmodule

bind dss_stream_seq dss_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_we(mem_we), .mem_addr(mem_addr), .tx_valid(tx_valid),
    .tx_data(tx_data), .rx_ready(rx_ready), .evt(evt), .evt_clr(evt_clr),
    .cfg_inten(cfg_inten), .irq(irq), .act_dir(act_dir)
);

// File: tb/sim_dss_stream_seq.sv
`timescale 1ns/1ps
module sim_dss_stream_seq;
    localparam int AW = 32, DW = 32, CW = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic [AW-1:0] cfg_tx_ptr = '0, cfg_rx_ptr = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [1:0] cfg_dir = 2'b00;
    logic [3:0] cfg_inten = '0, evt_clr = '0, evt;
    logic task_start = 1'b0, task_stop = 1'b0;
    logic irq, mem_req, mem_we, mem_ack = 1'b0, tx_valid, tx_ready = 1'b0;
    logic rx_valid = 1'b0, rx_ready;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata = '0, tx_data, rx_data = '0;

    dss_stream_seq #(.AW(AW), .DW(DW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_tx_ptr(cfg_tx_ptr), .cfg_rx_ptr(cfg_rx_ptr),
        .cfg_count(cfg_count), .cfg_dir(cfg_dir), .cfg_inten(cfg_inten),
        .task_start(task_start), .task_stop(task_stop), .evt_clr(evt_clr),
        .evt(evt), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
    );

    logic [31:0] mem [0:255];
    logic [31:0] tx_log [0:63];
    logic [31:0] rd_log [0:63];
    logic [31:0] wa_log [0:63];
    logic [31:0] wd_log [0:63];
    int tx_n = 0, rd_n = 0, wr_n = 0, rx_seq = 0, rxr_cnt = 0;
    int cyc = 0, last_hs = 0, stop_cyc = 0;
    bit stop_seen = 1'b0, finished = 1'b0;
    int nchk = 0, nerr = 0;

    function automatic logic [31:0] mem_val(int i);
        return 32'h5A000000 ^ (i * 32'h00010003);
    endfunction
    function automatic logic [31:0] rx_pat(int i);
        return 32'hC0DE0000 + i * 7;
    endfunction

    // Memory, engine sink and engine source models; log every handshake.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (evt[3] && !stop_seen) begin
            stop_seen = 1'b1;
            stop_cyc  = cyc;
        end
        mem_ack   = mem_req && (($urandom % 3) != 0);
        mem_rdata = (mem_req && !mem_we) ? mem[mem_addr[9:2]] : '0;
        tx_ready  = ($urandom % 4) != 0;
        rx_valid  = ($urandom % 4) != 0;
        rx_data   = rx_pat(rx_seq);
        #1;
        if (mem_req && mem_ack) begin
            last_hs = cyc;
            if (mem_we) begin
                mem[mem_addr[9:2]] = mem_wdata;
                if (wr_n < 64) begin wa_log[wr_n] = mem_addr; wd_log[wr_n] = mem_wdata; end
                wr_n = wr_n + 1;
            end else begin
                if (rd_n < 64) rd_log[rd_n] = mem_addr;
                rd_n = rd_n + 1;
            end
        end
        if (tx_valid && tx_ready) begin
            last_hs = cyc;
            if (tx_n < 64) tx_log[tx_n] = tx_data;
            tx_n = tx_n + 1;
        end
        if (rx_ready && rx_valid) begin
            last_hs = cyc;
            rx_seq  = rx_seq + 1;
        end
        if (rx_ready) rxr_cnt = rxr_cnt + 1;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        tx_n = 0; rd_n = 0; wr_n = 0; rx_seq = 0; rxr_cnt = 0;
    endtask

    task automatic pulse_start();
        task_start = 1'b1; @(negedge clk); task_start = 1'b0;
    endtask

    task automatic pulse_stop();
        task_stop = 1'b1; @(negedge clk); task_stop = 1'b0;
    endtask

    task automatic clr_evt(input logic [3:0] m);
        evt_clr = m; @(negedge clk); evt_clr = '0;
        if (m[3]) stop_seen = 1'b0;
    endtask

    task automatic wait_tx(input int n);
        for (int t = 0; t < 5000 && tx_n < n; t++) @(negedge clk);
    endtask

    task automatic wait_wr(input int n);
        for (int t = 0; t < 5000 && wr_n < n; t++) @(negedge clk);
    endtask

    task automatic wait_stop();
        for (int t = 0; t < 5000 && !stop_seen; t++) @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = mem_val(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "evt", {28'd0, evt}, 32'd0);
        chk("R1", "irq/req/txv/rxr", {28'd0, irq, mem_req, tx_valid, rx_ready}, 32'd0);

        // R11: zero count, empty direction, stop while idle
        cfg_inten = 4'hF; cfg_tx_ptr = 32'h100; cfg_dir = 2'b01; cfg_count = 0;
        clear_logs(); pulse_start(); repeat (10) @(negedge clk);
        chk("R11", "zero count start evt", {28'd0, evt}, 32'd0);
        chk("R11", "zero count start reads", rd_n, 0);
        cfg_dir = 2'b00; cfg_count = 4; pulse_start(); repeat (10) @(negedge clk);
        chk("R11", "empty dir start evt+reads", {28'd0, evt} | rd_n, 32'd0);
        pulse_stop(); repeat (3) @(negedge clk);
        chk("R11", "idle stop evt", {28'd0, evt}, 32'd0);

        // R2 R3 R4 R7: transmit only, replay then pointer rewrite
        cfg_inten = 4'b0001; cfg_tx_ptr = 32'h100; cfg_count = 4; cfg_dir = 2'b01;
        clear_logs(); pulse_start();
        chk("R2", "tx-only start events", {28'd0, evt}, 32'h1);
        chk("R10", "tx-only irq with tx enable", {31'd0, irq}, 32'd1);
        wait_tx(6);
        cfg_tx_ptr = 32'h200;
        wait_tx(12);
        pulse_stop(); wait_stop();
        for (int k = 0; k < 12; k++) begin
            int base;
            base = (k < 8) ? 32'h100 : 32'h200;
            chk("R4", $sformatf("tx word %0d", k), tx_log[k], mem_val(base / 4 + k % 4));
            chk("R3", $sformatf("read addr %0d", k), rd_log[k], base + 4 * (k % 4));
        end
        chk("R7", "count-reached event", {31'd0, evt[2]}, 32'd1);
        chk("R4", "no writes, rx_ready idle", wr_n + rxr_cnt, 0);
        chk("R8", "stop latency tx-only", stop_cyc - last_hs, 1);
        clr_evt(4'hF);
        chk("R9", "clear all events", {28'd0, evt}, 32'd0);

        // R5 R7: receive only
        cfg_inten = 4'b0010; cfg_rx_ptr = 32'h300; cfg_count = 3; cfg_dir = 2'b10;
        clear_logs(); pulse_start();
        chk("R2", "rx-only start events", {28'd0, evt}, 32'h2);
        chk("R10", "rx-only irq", {31'd0, irq}, 32'd1);
        wait_wr(6);
        pulse_stop(); wait_stop();
        for (int k = 0; k < 6; k++) begin
            chk("R5", $sformatf("zero tx word %0d", k), tx_log[k], 32'd0);
            chk("R5", $sformatf("rx data %0d", k), wd_log[k], rx_pat(k));
            chk("R7", $sformatf("rx replay addr %0d", k), wa_log[k], 32'h300 + 4 * (k % 3));
        end
        chk("R5", "no reads", rd_n, 0);
        chk("R8", "stop latency rx-only", stop_cyc - last_hs, 1);
        clr_evt(4'hF);

        // R6 R8: duplex with early stop
        cfg_inten = 4'b0000; cfg_tx_ptr = 32'h100; cfg_rx_ptr = 32'h300;
        cfg_count = 4; cfg_dir = 2'b11;
        clear_logs(); pulse_start();
        chk("R2", "duplex start events", {28'd0, evt}, 32'h3);
        chk("R10", "duplex irq disabled", {31'd0, irq}, 32'd0);
        wait_tx(3);
        pulse_stop(); wait_stop();
        chk("R8", "duplex word completes", wr_n, tx_n);
        chk("R8", "stop latency duplex", stop_cyc - last_hs, 1);
        chk("R8", "no request after stop", {31'd0, mem_req}, 32'd0);
        for (int k = 0; k < wr_n && k < 8; k++) begin
            chk("R6", $sformatf("duplex tx %0d", k), tx_log[k], mem_val(32'h100 / 4 + k % 4));
            chk("R6", $sformatf("duplex rx data %0d", k), wd_log[k], rx_pat(k));
            chk("R6", $sformatf("duplex rx addr %0d", k), wa_log[k], 32'h300 + 4 * (k % 4));
        end

        // R9 R10: leftover rx pointer-update bit is masked in tx-only mode
        clr_evt(4'b1000);
        cfg_inten = 4'b0010; cfg_dir = 2'b01; cfg_count = 2;
        clear_logs(); pulse_start();
        chk("R9", "leftover rx event kept", {31'd0, evt[1]}, 32'd1);
        chk("R10", "inactive-direction irq masked", {31'd0, irq}, 32'd0);
        cfg_inten = 4'b0001; #1;
        chk("R10", "active-direction irq", {31'd0, irq}, 32'd1);
        pulse_stop(); wait_stop();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule